// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for an 8-bit successive-approximation converter. It does not contain the resistor ladder, the analog switches or the comparator. The block drives a trial code that selects a ladder tap, and it reads back a single comparator bit. It resolves the result one bit at a time, starting at the most significant bit. Each bit gets an eight-clock slot, so a full conversion lasts 64 clocks. When the last bit is settled, the code is copied into a result latch and an active-low interrupt is raised.

A conversion is requested by holding chip-select and write low together. While both are low, the sequencer is held cleared and a start flag is armed. Once either line returns high, the start flag drops at the next boundary of the free-running eight-clock slot, and the most significant trial begins. Because of this, the start latency varies from one to eight clocks. Taking write low again while a conversion runs aborts it. Tying the interrupt output back to write, with chip-select held low, produces back-to-back conversions. A read with chip-select low enables the result onto the bus and clears the interrupt.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While cs_n and wr_n are both low at a clock edge, the next cycle shows trial_o = 0 and intr_n = 1.
- R2: After the last clock edge that samples cs_n and wr_n both low, trial_o changes to 8'h80 within 1 to 8 clock edges. Which value in that range occurs depends only on the position inside the free-running 8-clock slot, so every value from 1 to 8 can occur.
- R3: During a conversion, trial_o changes only on slot boundaries, that is, a multiple of 8 clocks after the start edge.
- R4: The first trial code of a conversion is 8'h80. At any time, the bit under test is the only one of the undecided bits that is set.
- R5: When a slot ends, a high cmp_i keeps the bit under test and a low cmp_i clears it. The next lower bit is set for the following trial, so after the first slot trial_o = (target & 8'h80) | 8'h40.
- R6: intr_n goes low exactly 64 clocks after the edge that starts the conversion, and data_o then holds the settled code.
- R7: With the comparator acting as (trial_o <= target), every target from 0 to 255 produces data_o = target. Target 255 (full scale) gives 8'hFF.
- R8: While cs_n and rd_n are both low, data_oe is 1 and data_o shows the latch. intr_n returns to 1 on the next edge.
- R9: Driving wr_n low with cs_n low during a conversion abandons it. The next cycle shows trial_o = 0, and a later release runs a fresh conversion correctly.
- R10: When wr_n is driven from intr_n and cs_n is held low, conversions repeat every 72 clocks, each one yielding the target code.
- R11: A low rd_n while cs_n is high leaves data_oe at 0 and intr_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| cs_n | input | 1 | Chip-select, active low |
| wr_n | input | 1 | Start or reset request, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the selected tap |
| trial_o | output | 8 | Trial code driving the ladder switches |
| data_o | output | 8 | Result latch |
| data_oe | output | 1 | Enable for the result bus drivers |
| intr_n | output | 1 | Conversion complete, active low |

## Verification
The assertions assume that cmp_i is meaningful only at the close of each slot. They also assume that the only source of reset is cs_n and wr_n being low together, so the clocked properties are disabled during that hold. In the stimulus, the comparator is a pure function of trial_o and a target that stays fixed for the whole conversion. All control lines change on the falling edge. Hold lengths of 1 to 8 cycles sweep the release point across every slot phase.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int unsigned DEF_RES_W     = 8;
    localparam int unsigned DEF_SLOT_CLKS = 8;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_mode_e;

    typedef struct packed {
        logic armed;
    } start_state_t;
endpackage

// File: rtl/sar_slot_timer.sv
module sar_slot_timer #(
    parameter int unsigned SLOT_CLKS = 8
) (
    input  logic clk,
    output logic slot_end
);
    localparam int unsigned CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // Free-running slot phase; never reset so the start latency tracks it.
    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.phase == LAST) tmr_d.phase = '0;
        else                     tmr_d.phase = tmr_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign slot_end = (tmr_q.phase == LAST);
endmodule

// File: rtl/sar_start_ctl.sv
module sar_start_ctl
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic hold,
    input  logic slot_end,
    output logic go
);
    start_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold)                         st_d.armed = 1'b1;
        else if (st_q.armed && slot_end)  st_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign go = st_q.armed && slot_end && !hold;

    // R2: the armed flag only drops on a slot boundary
    assert_start_on_boundary_R2: assert property (@(posedge clk) disable iff (hold)
        $fell(st_q.armed) |-> $past(slot_end));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             hold,
    input  logic             go,
    input  logic             slot_end,
    input  logic             cmp_i,
    input  logic             rd_req,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        eng_mode_e        mode;
        logic [RES_W-1:0] walk;
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] result;
        logic             irq;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [RES_W-1:0] decided;
    logic             finish;

    // Per-bit decision: keep/clear the tested bit, raise the next one down.
    for (genvar b = 0; b < RES_W; b++) begin : g_bit
        if (b == RES_W - 1) begin : g_top
            assign decided[b] = eng_q.walk[b] ? cmp_i : eng_q.sar[b];
        end else begin : g_low
            assign decided[b] = eng_q.walk[b]   ? cmp_i :
                                eng_q.walk[b+1] ? 1'b1  : eng_q.sar[b];
        end
    end

    assign finish = (eng_q.mode == ENG_RUN) && slot_end && eng_q.walk[0];

    always_comb begin
        eng_d = eng_q;
        if (hold) begin
            eng_d.mode = ENG_IDLE;
            eng_d.walk = '0;
            eng_d.sar  = '0;
            eng_d.irq  = 1'b0;
        end else begin
            if (rd_req) eng_d.irq = 1'b0;
            if (go) begin
                eng_d.mode = ENG_RUN;
                eng_d.walk = TOP_BIT;
                eng_d.sar  = TOP_BIT;
            end else if (eng_q.mode == ENG_RUN && slot_end) begin
                eng_d.sar  = decided;
                eng_d.walk = eng_q.walk >> 1;
                if (eng_q.walk[0]) begin
                    eng_d.mode   = ENG_IDLE;
                    eng_d.result = decided;
                    eng_d.irq    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        eng_q <= eng_d;
    end

    assign trial  = eng_q.sar;
    assign result = eng_q.result;
    assign irq    = eng_q.irq;

    // R3: the trial code holds still between slot boundaries
    assert_trial_stable_R3: assert property (@(posedge clk) disable iff (hold)
        !slot_end |=> $stable(eng_q.sar));
    // R4: at most one bit under test
    assert_single_walk_bit_R4: assert property (@(posedge clk) disable iff (hold)
        $onehot0(eng_q.walk));
    // R6: interrupt rises only after the last bit is settled
    assert_irq_after_lsb_R6: assert property (@(posedge clk) disable iff (hold)
        $rose(eng_q.irq) |-> $past(eng_q.walk[0] && slot_end));
    // R8: a read with no completion in the same cycle clears the interrupt
    assert_read_clears_irq_R8: assert property (@(posedge clk) disable iff (hold)
        (rd_req && !finish) |=> !eng_q.irq);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W     = DEF_RES_W,
    parameter int unsigned SLOT_CLKS = DEF_SLOT_CLKS
) (
    input  logic             clk,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] data_o,
    output logic             data_oe,
    output logic             intr_n
);
    logic hold;
    logic rd_req;
    logic slot_end;
    logic go;
    logic irq;

    assign hold   = !cs_n && !wr_n;
    assign rd_req = !cs_n && !rd_n;

    sar_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk      (clk),
        .slot_end (slot_end)
    );

    sar_start_ctl u_start (
        .clk      (clk),
        .hold     (hold),
        .slot_end (slot_end),
        .go       (go)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_engine (
        .clk      (clk),
        .hold     (hold),
        .go       (go),
        .slot_end (slot_end),
        .cmp_i    (cmp_i),
        .rd_req   (rd_req),
        .trial    (trial_o),
        .result   (data_o),
        .irq      (irq)
    );

    assign data_oe = rd_req;
    assign intr_n  = !irq;

    // R1: a held request clears the trial code and the interrupt
    // (hold is the block's only reset, so this property is not disabled)
    assert_hold_clears_R1: assert property (@(posedge clk)
        hold |=> (trial_o == '0 && intr_n));
endmodule

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
    logic       clk = 1'b0;
    logic       cs_n = 1'b0;
    logic       wr_r = 1'b0;
    logic       rd_n = 1'b1;
    logic       free_run = 1'b0;
    logic [7:0] tgt = 8'h00;
    logic       wr_n;
    logic       cmp;
    logic [7:0] trial_o, data_o;
    logic       data_oe, intr_n;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] lat_seen = 8'h00;

    always #10 clk = ~clk;

    assign wr_n = free_run ? intr_n : wr_r;
    assign cmp  = (trial_o <= tgt);

    sar_seq_ctrl dut (
        .clk(clk), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .cmp_i(cmp),
        .trial_o(trial_o), .data_o(data_o), .data_oe(data_oe), .intr_n(intr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic [7:0] t, input int hold_cyc);
        int lat;
        int cnt;
        bit steady;
        logic [7:0] prev;
        @(negedge clk);
        tgt = t; cs_n = 1'b0; wr_r = 1'b0; rd_n = 1'b1;
        repeat (hold_cyc) @(negedge clk);
        wr_r = 1'b1;
        lat = 0;
        do begin
            @(negedge clk); lat++;
        end while (trial_o != 8'h80 && lat < 20);
        chk(lat >= 1 && lat <= 8, "R2 start latency", lat, 8);
        chk(trial_o == 8'h80, "R4 first trial", trial_o, 8'h80);
        if (lat >= 1 && lat <= 8) lat_seen[lat-1] = 1'b1;
        cnt = 0; steady = 1'b1; prev = trial_o;
        do begin
            @(negedge clk); cnt++;
            if (trial_o != prev && (cnt % 8) != 0) steady = 1'b0;
            if (cnt == 8)
                chk(trial_o == ((t & 8'h80) | 8'h40), "R5 first decision",
                    trial_o, (t & 8'h80) | 8'h40);
            prev = trial_o;
        end while (intr_n != 1'b0 && cnt < 100);
        chk(steady, "R3 slot-aligned trial changes", steady, 1);
        chk(cnt == 64, "R6 completion time", cnt, 64);
        chk(data_o == t, "R7 result code", data_o, t);
        // R11: read without chip-select
        cs_n = 1'b1; rd_n = 1'b0;
        #1 chk(data_oe == 1'b0, "R11 no enable without select", data_oe, 0);
        @(negedge clk);
        chk(intr_n == 1'b0, "R11 interrupt kept", intr_n, 0);
        // R8: selected read
        cs_n = 1'b0;
        #1 chk(data_oe == 1'b1 && data_o == t, "R8 read enable", data_oe, 1);
        @(negedge clk);
        chk(intr_n == 1'b1, "R8 read clears interrupt", intr_n, 1);
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(trial_o == 8'h00, "R1 held trial", trial_o, 0);
        chk(intr_n == 1'b1, "R1 held interrupt", intr_n, 1);
        chk(data_oe == 1'b0, "R1 no enable", data_oe, 0);

        for (int t = 0; t < 256; t++) run_conv(8'(t), 1 + (t % 8));
        chk(lat_seen == 8'hFF, "R2 every latency seen", lat_seen, 8'hFF);

        // R9: abort mid-conversion
        @(negedge clk);
        tgt = 8'hAA; cs_n = 1'b0; wr_r = 1'b0;
        @(negedge clk); wr_r = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (trial_o != 8'h80 && cnt < 20);
        repeat (20) @(negedge clk);
        wr_r = 1'b0;
        @(negedge clk);
        chk(trial_o == 8'h00, "R9 abort clears trial", trial_o, 0);
        chk(intr_n == 1'b1, "R9 abort interrupt idle", intr_n, 1);
        run_conv(8'h3B, 2);
        run_conv(8'hFF, 5);
        chk(data_o == 8'hFF, "R7 full scale", data_o, 8'hFF);

        // R10: free-running loop
        @(negedge clk);
        tgt = 8'h5C; cs_n = 1'b0; wr_r = 1'b0;
        @(negedge clk);
        wr_r = 1'b1; free_run = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (intr_n != 1'b0 && cnt < 200);
        chk(data_o == 8'h5C, "R10 first free-run result", data_o, 8'h5C);
        for (int k = 0; k < 3; k++) begin
            tgt = (k == 1) ? 8'hE1 : 8'h5C;
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (intr_n != 1'b0 && cnt < 200);
            chk(cnt == 72, "R10 free-run period", cnt, 72);
            chk(data_o == tgt, "R10 free-run result", data_o, tgt);
        end
        free_run = 1'b0; wr_r = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule